// File: doc/BRIEF.md
# Task-Set Page Mapper

This block sits between an 8-bit host CPU and its memories. Each 16-bit CPU address is split into a 4 kB page number and an offset. The page number and the active task number together pick one byte from a mapping table. That byte decides whether the access stays in internal RAM or goes to one 4 kB block of a 512 kB external RAM. The table holds 256 task sets of sixteen page slots each and sits in an on-chip synchronous memory. Software switches between whole address-space layouts with one register write.

Software reaches the block through a small register port. One location holds the active task number. Sixteen quick-select locations each jump straight to one of the tasks 0 to 15. A sixteen-byte window reads and writes the slots of the active task. After reset a sweep sets every table entry to zero, so every page starts out in internal RAM. A status output shows when the sweep has finished.

Top module: `task_page_mapper`

## Requirements
- R1: A translation request (`xlatValid` high at a rising edge) produces `outValid` high with its result in the following cycle. The page index is `cpuAddr[15:12]` and the offset is `cpuAddr[11:0]`.
- R2: Pages 0 and 13 (0x0000-0x0FFF and 0xD000-0xDFFF) always go to internal memory (`extSel` = 0), whatever their slot holds.
- R3: An internal result drives `extSel` = 0 and `physAddr` = {3'b000, cpuAddr}. Any page whose slot holds 0 gives an internal result.
- R4: A remappable page whose slot holds a nonzero value E drives `extSel` = 1 and `physAddr` = {E[6:0], cpuAddr[11:0]}. Bit 7 of E plays no part.
- R5: Register address 0x00 holds the 8-bit active task. Writing it changes the task, reading it returns the task, and the lookup uses entry {task, page}.
- R6: A write to register address 0x10+k (k = 0..15) makes task k active, whatever the write data.
- R7: A write to register address 0x20+p stores the data in slot p of the active task. A read of 0x20+p returns that slot. Every read answers one cycle after `regRdEn` with `regRdValid` high. Addresses other than 0x00 and 0x20-0x2F read as 0.
- R8: After reset the task is 0 and `initDone` stays low while all 4096 entries are cleared, one per cycle. While the clear runs, translations report internal and window writes are dropped.
- R9: If a translation and a window write hit the same entry at the same edge, the translation returns the entry's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlatValid | input | 1 | Translation request strobe |
| cpuAddr | input | 16 | CPU address to translate |
| outValid | output | 1 | Translation result valid |
| extSel | output | 1 | 1 = external RAM access, 0 = internal RAM |
| physAddr | output | 19 | Translated physical address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 6 | Register address (task, quick-select, window) |
| regWrData | input | 8 | Register write data |
| regRdValid | output | 1 | Register read data valid |
| regRdData | output | 8 | Register read data |
| initDone | output | 1 | High once the table clear has finished |

## Verification
The assertions check four things on every cycle: fixed pages never leave internal memory, the offset always passes through unchanged, results and read data follow their strobes by exactly one cycle, and a quick-select write always loads its own index. None of them can see whether the right table entry was chosen for a given {task, page} pair. Only the bench's scenarios can show that: they program entries in several tasks, switch between tasks and read back, and check that a stale write made during the clear is gone.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  // Register regions, decoded from the upper bits of the register address.
  typedef enum logic [1:0] {
    RG_TASK  = 2'd0,
    RG_QUICK = 2'd1,
    RG_WIN   = 2'd2,
    RG_NONE  = 2'd3
  } regRegion_e;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic tblWrite;
    logic winRead;
    logic taskRead;
    logic initDone;
  } ctrlStrobes_t;

endpackage

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
  import tpm_pkg::*;
#(
  parameter int TASK_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int DATA_W  = 8,
  parameter int REG_AW  = PAGE_W + 2,
  localparam int IDX_W  = TASK_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [TASK_W-1:0] taskQ,
  output logic [IDX_W-1:0]  clearIdx,
  output ctrlStrobes_t      strb
);

  regRegion_e         region;
  logic [PAGE_W-1:0]  slotIdx;
  logic               isTaskReg;
  logic               clearing;

  assign region    = regRegion_e'(regAddr[REG_AW-1:PAGE_W]);
  assign slotIdx   = regAddr[PAGE_W-1:0];
  assign isTaskReg = (region == RG_TASK) && (slotIdx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taskQ    <= '0;
      clearing <= 1'b1;
      clearIdx <= '0;
    end else begin
      if (clearing) begin
        clearIdx <= clearIdx + 1'b1;
        if (clearIdx == {IDX_W{1'b1}}) clearing <= 1'b0;
      end
      if (regWrEn && isTaskReg)
        taskQ <= regWrData[TASK_W-1:0];
      else if (regWrEn && region == RG_QUICK)
        taskQ <= TASK_W'(slotIdx);
    end
  end

  always_comb begin
    strb.tblWrite = clearing || (regWrEn && region == RG_WIN);
    strb.winRead  = regRdEn && region == RG_WIN;
    strb.taskRead = regRdEn && isTaskReg;
    strb.initDone = !clearing;
  end

  // R6: a quick-select write loads its own index as the task
  a_r6_quick_select: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr[REG_AW-1:PAGE_W] == 2'd1)
      |=> taskQ == TASK_W'($past(regAddr[PAGE_W-1:0])));

  // R8: once finished, the clear never restarts without reset
  a_r8_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    strb.initDone |=> strb.initDone);

endmodule

// File: rtl/tpm_datapath.sv
module tpm_datapath
  import tpm_pkg::*;
#(
  parameter int TASK_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int OFF_W       = 12,
  parameter int DATA_W      = 8,
  parameter int FIXED_PG_A  = 0,
  parameter int FIXED_PG_B  = 13,
  localparam int IDX_W      = TASK_W + PAGE_W,
  localparam int DEPTH      = 1 << IDX_W,
  localparam int ADDR_W     = PAGE_W + OFF_W,
  localparam int PHYS_W     = DATA_W - 1 + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [TASK_W-1:0] taskQ,
  input  logic [IDX_W-1:0]  clearIdx,
  input  logic [PAGE_W-1:0] slotIdx,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  input  logic              xlatValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              outValid,
  output logic              extSel,
  output logic [PHYS_W-1:0] physAddr,
  output logic              regRdValid,
  output logic [DATA_W-1:0] regRdData
);

  logic [DATA_W-1:0] tbl [DEPTH];

  logic [IDX_W-1:0]  wrIdx;
  logic [DATA_W-1:0] wrVal;
  logic [PAGE_W-1:0] reqPage;

  logic [DATA_W-1:0] xEntry, winEntry;
  logic [TASK_W-1:0] taskRdQ;
  logic [PAGE_W-1:0] pageQ;
  logic [OFF_W-1:0]  offQ;
  logic              validQ, liveQ, rdWinQ, rdTaskQ;
  logic              pageFixed;

  assign reqPage = cpuAddr[ADDR_W-1:OFF_W];
  assign wrIdx   = strb.initDone ? {taskQ, slotIdx} : clearIdx;
  assign wrVal   = strb.initDone ? regWrData : '0;

  // Table: one write port, two read ports, read-first on a collision.
  always_ff @(posedge clk) begin
    if (strb.tblWrite) tbl[wrIdx] <= wrVal;
    xEntry   <= tbl[{taskQ, reqPage}];
    winEntry <= tbl[{taskQ, slotIdx}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ     <= 1'b0;
      liveQ      <= 1'b0;
      pageQ      <= '0;
      offQ       <= '0;
      regRdValid <= 1'b0;
      rdWinQ     <= 1'b0;
      rdTaskQ    <= 1'b0;
      taskRdQ    <= '0;
    end else begin
      validQ     <= xlatValid;
      liveQ      <= strb.initDone;
      pageQ      <= reqPage;
      offQ       <= cpuAddr[OFF_W-1:0];
      regRdValid <= regRdEn;
      rdWinQ     <= strb.winRead;
      rdTaskQ    <= strb.taskRead;
      taskRdQ    <= taskQ;
    end
  end

  assign pageFixed = (pageQ == PAGE_W'(FIXED_PG_A)) || (pageQ == PAGE_W'(FIXED_PG_B));

  always_comb begin
    extSel   = validQ && liveQ && !pageFixed && (xEntry != '0);
    outValid = validQ;
    physAddr = extSel ? {xEntry[DATA_W-2:0], offQ} : PHYS_W'({pageQ, offQ});
    if (rdWinQ)       regRdData = winEntry;
    else if (rdTaskQ) regRdData = DATA_W'(taskRdQ);
    else              regRdData = '0;
  end

  // R2: fixed pages never reach external memory
  a_r2_fixed_internal: assert property (@(posedge clk) disable iff (!rst_n)
    extSel |-> ($past(cpuAddr[ADDR_W-1:OFF_W]) != PAGE_W'(FIXED_PG_A) &&
                $past(cpuAddr[ADDR_W-1:OFF_W]) != PAGE_W'(FIXED_PG_B)));

  // R4: offset passes through unchanged
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> physAddr[OFF_W-1:0] == $past(cpuAddr[OFF_W-1:0]));

  // R1: one-cycle translation latency
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    xlatValid |=> outValid);

  // R7: read data valid one cycle after the read strobe
  a_r7_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    regRdEn |=> regRdValid);

  // R1: no external select without a request
  a_r1_idle_internal: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> !extSel);

endmodule

// File: rtl/task_page_mapper.sv
module task_page_mapper
  import tpm_pkg::*;
#(
  parameter int TASK_W     = 8,
  parameter int PAGE_W     = 4,
  parameter int OFF_W      = 12,
  parameter int DATA_W     = 8,
  parameter int FIXED_PG_A = 0,
  parameter int FIXED_PG_B = 13,
  localparam int ADDR_W    = PAGE_W + OFF_W,
  localparam int PHYS_W    = DATA_W - 1 + OFF_W,
  localparam int REG_AW    = PAGE_W + 2,
  localparam int IDX_W     = TASK_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlatValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              outValid,
  output logic              extSel,
  output logic [PHYS_W-1:0] physAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              regRdValid,
  output logic [DATA_W-1:0] regRdData,
  output logic              initDone
);

  ctrlStrobes_t      strb;
  logic [TASK_W-1:0] taskQ;
  logic [IDX_W-1:0]  clearIdx;

  tpm_ctrl #(
    .TASK_W(TASK_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .taskQ(taskQ), .clearIdx(clearIdx), .strb(strb)
  );

  tpm_datapath #(
    .TASK_W(TASK_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
    .FIXED_PG_A(FIXED_PG_A), .FIXED_PG_B(FIXED_PG_B)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .taskQ(taskQ), .clearIdx(clearIdx),
    .slotIdx(regAddr[PAGE_W-1:0]), .regWrData(regWrData), .regRdEn(regRdEn),
    .xlatValid(xlatValid), .cpuAddr(cpuAddr),
    .outValid(outValid), .extSel(extSel), .physAddr(physAddr),
    .regRdValid(regRdValid), .regRdData(regRdData)
  );

  assign initDone = strb.initDone;

endmodule

// File: tb/tb_task_page_mapper.sv
module tb_task_page_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlatValid = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        outValid, extSel;
  logic [18:0] physAddr;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        regRdValid;
  logic [7:0]  regRdData;
  logic        initDone;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;  // 250 MHz

  task_page_mapper dut (
    .clk(clk), .rst_n(rst_n), .xlatValid(xlatValid), .cpuAddr(cpuAddr),
    .outValid(outValid), .extSel(extSel), .physAddr(physAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdValid(regRdValid), .regRdData(regRdData), .initDone(initDone)
  );

  // {task[7:0], page[3:0], entry[7:0], offset[11:0]}
  localparam logic [31:0] VEC [8] = '{
    {8'd0,   4'd12, 8'h03, 12'h123},
    {8'd0,   4'd0,  8'h05, 12'h456},
    {8'd0,   4'd13, 8'h09, 12'h789},
    {8'd1,   4'd12, 8'h00, 12'hABC},
    {8'd200, 4'd15, 8'h85, 12'h00F},
    {8'd255, 4'd1,  8'h7F, 12'hFFF},
    {8'd7,   4'd14, 8'h40, 12'h000},
    {8'd16,  4'd2,  8'h01, 12'h800}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
    check(regRdValid === 1'b1, "R7 rdvalid", int'(regRdValid), 1);
  endtask

  task automatic xlat(input logic [15:0] a, output logic ext, output logic [18:0] pa);
    @(negedge clk);
    xlatValid = 1'b1; cpuAddr = a;
    @(negedge clk);
    xlatValid = 1'b0;
    ext = extSel; pa = physAddr;
    check(outValid === 1'b1, "R1 outValid", int'(outValid), 1);
  endtask

  function automatic logic [18:0] expPhys(input logic [3:0] pg, input logic [7:0] e,
                                          input logic [11:0] off);
    if (e != 0 && pg != 0 && pg != 13) return {e[6:0], off};
    return {3'b000, pg, off};
  endfunction

  task automatic runMain();
    logic [7:0]  d;
    logic        ext;
    logic [18:0] pa;
    int          cyc;
    // reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(initDone === 1'b0, "R8 clearing after reset", int'(initDone), 0);
    regRead(6'h00, d);
    check(d === 8'h00, "R8 task after reset", int'(d), 0);
    regWrite(6'h25, 8'h07);              // dropped during the clear
    xlat(16'h5123, ext, pa);
    check(ext === 1'b0, "R8 internal while clearing", int'(ext), 0);
    cyc = 0;
    while (initDone !== 1'b1 && cyc < 6000) begin @(negedge clk); cyc++; end
    check(initDone === 1'b1 && cyc > 4000, "R8 clear duration", cyc, 4090);
    regRead(6'h25, d);
    check(d === 8'h00, "R8 write during clear dropped", int'(d), 0);
    xlat(16'h5123, ext, pa);
    check(ext === 1'b0 && pa === 19'h05123, "R3 cleared slot internal", int'(pa), 'h05123);

    // vector table
    foreach (VEC[i]) begin
      logic [7:0]  vt;
      logic [3:0]  vp;
      logic [7:0]  ve;
      logic [11:0] vo;
      logic [18:0] ep;
      {vt, vp, ve, vo} = VEC[i];
      ep = expPhys(vp, ve, vo);
      regWrite(6'h00, vt);
      regWrite({2'b10, vp}, ve);
      regRead({2'b10, vp}, d);
      check(d === ve, "R7 window readback", int'(d), int'(ve));
      regRead(6'h00, d);
      check(d === vt, "R5 task readback", int'(d), int'(vt));
      xlat({vp, vo}, ext, pa);
      check(ext === (ep[18:16] != 0 || (ve != 0 && vp != 0 && vp != 13)),
            "R2/R4 extSel", int'(ext), int'(ve != 0 && vp != 0 && vp != 13));
      check(pa === ep, "R3/R4 physAddr", int'(pa), int'(ep));
    end

    // R5: task isolation - task 0 slot 12 still holds 3, task 1 slot 12 holds 0
    regWrite(6'h00, 8'd1);
    xlat(16'hC010, ext, pa);
    check(ext === 1'b0, "R5 task1 page12 internal", int'(ext), 0);
    regWrite(6'h00, 8'd0);
    xlat(16'hC010, ext, pa);
    check(ext === 1'b1 && pa === 19'h03010, "R5 task0 page12", int'(pa), 'h03010);

    // R6: quick-select ignores data
    regWrite(6'h17, 8'hAA);
    regRead(6'h00, d);
    check(d === 8'd7, "R6 quick select 7", int'(d), 7);
    xlat(16'hE234, ext, pa);
    check(ext === 1'b1 && pa === 19'h40234, "R6 task7 page14", int'(pa), 'h40234);
    regWrite(6'h1F, 8'h00);
    regRead(6'h00, d);
    check(d === 8'd15, "R6 quick select 15", int'(d), 15);

    // R7: unmapped addresses read 0
    regRead(6'h05, d);
    check(d === 8'h00, "R7 unmapped read", int'(d), 0);
    regRead(6'h13, d);
    check(d === 8'h00, "R7 quick read", int'(d), 0);

    // R9: collision read-first (task 15, slot 9 currently 0)
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 6'h29; regWrData = 8'h22;
    xlatValid = 1'b1; cpuAddr = 16'h9ABC;
    @(negedge clk);
    regWrEn = 1'b0; xlatValid = 1'b0;
    check(extSel === 1'b0, "R9 old value on collision", int'(extSel), 0);
    xlat(16'h9ABC, ext, pa);
    check(ext === 1'b1 && pa === 19'h22ABC, "R9 new value after", int'(pa), 'h22ABC);
  endtask

  initial begin
    fork
      runMain();
      begin
        repeat (20000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule